// File: doc/BRIEF.md
# Interrupt Message Controller

This block watches eleven level-sensitive interrupt sources, samples their levels every clock, and turns each new 0-to-1 transition of an enabled source into one outbound memory-write message to a CPU. A per-source class bit chooses between two programmable target registers. The target register packs both parts of the message: the upper bits give the write address, aligned to 32 bytes, and the low five bits give the data value. Software sees the sampled levels, a sticky record of rising edges that clears on any access, and two routed views that split the enabled, asserted sources by class.

Messages leave through a valid/ready port, one at a time. When several enabled sources rise together, each one gets its own queued message, and the queue sends them lowest source index first. A small two-state dispatcher drives the port. In `ST_IDLE`, if any message is queued, it takes the lowest one, loads its address and data, and moves to `ST_SEND`. In `ST_SEND`, it stays while `msg_ready` is low and returns to `ST_IDLE` on the cycle the message is accepted.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset every register reads zero and `msg_valid` is low.
- R2: The level register at offset 0x028 returns, in bits 10:0, the source levels sampled at the last clock edge. Bit 9 is not implemented and always reads 0. Bits 31:11 read 0.
- R3: A pending bit in the register at 0x01C is set when its source is sampled high after being sampled low. A source falling never clears its pending bit.
- R4: Reading 0x01C returns the current pending bits and then clears them. Writing 0x01C clears them, whatever the data and byte enables. A rise sampled at the same edge as the clear stays set.
- R5: The routed view at 0x00C reads level AND enable AND NOT class. The routed view at 0x014 reads level AND enable AND class. Bits 31:11 of both read 0.
- R6: Writes to 0x028, 0x00C and 0x014 have no effect.
- R7: Four registers are writable: target-0 (0x004), target-1 (0x010), enable (0x018) and class (0x024). Each byte lane updates only when its enable `reg_be[i]` (bits 8i+7:8i) is set. Enable and class keep bits 10:0. Reads of any other offset return 0, and writes to other offsets change nothing.
- R8: A message's address is its target register with bits 4:0 cleared. Its data is bits 4:0 of the same register, in `msg_data[4:0]`, with all higher bits zero. The target is target-1 if the source's class bit was 1 at the edge that saw its rise, otherwise target-0. The target value is read when the message is loaded.
- R9: A rise seen while the source's enable bit is 0 never produces a message, even if the enable bit is set later.
- R10: Queued messages go out lowest source index first. A rise of a source whose message is still queued does not add a second message.
- R11: `msg_valid` stays high, with `msg_addr` and `msg_data` unchanged, until `msg_ready` is seen high. The cycle after an acceptance, `msg_valid` is low.
- R12: With the dispatcher idle and nothing queued, `msg_valid` rises at the clock edge after the edge that sampled the rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | 4 | Byte-lane enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as `reg_rd` |
| src_lvl | input | 11 | Interrupt source levels |
| msg_valid | output | 1 | Outbound message present |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
Each internal state shows at the ports within a cycle or two. A wrong level register shows up in the level and routed reads the cycle after the source changes. A corrupted pending bit stays visible until the next read, and since that read also clears, a missed or extra clear shows on the read that follows. A queue bit that is lost, duplicated or taken in the wrong order changes the sequence of addresses at the message port, once earlier messages drain. A dispatcher stuck in the wrong state shows as a valid that drops too early or never rises. The reference model compares every one of these outputs on every clock.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

    // register byte offsets (software visible map)
    localparam int OFS_TGT0   = 'h004;
    localparam int OFS_ROUTE0 = 'h00C;
    localparam int OFS_TGT1   = 'h010;
    localparam int OFS_ROUTE1 = 'h014;
    localparam int OFS_ENA    = 'h018;
    localparam int OFS_PEND   = 'h01C;
    localparam int OFS_CLASS  = 'h024;
    localparam int OFS_LEVEL  = 'h028;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } disp_state_e;

endpackage

// File: rtl/irq_msg_capture.sv
module irq_msg_capture #(
    parameter int              NSRC      = 11,
    parameter logic [NSRC-1:0] IMPL_MASK = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_lvl,
    input  logic            pend_clr,
    output logic [NSRC-1:0] level,
    output logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] rise
);
    logic [NSRC-1:0] src_m;

    assign src_m = src_lvl & IMPL_MASK;
    assign rise  = src_m & ~level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
            pend  <= '0;
        end else begin
            level <= src_m;
            pend  <= (pend_clr ? '0 : pend) | rise;
        end
    end
endmodule

// File: rtl/irq_msg_regs.sv
module irq_msg_regs
    import irq_msg_pkg::*;
#(
    parameter int NSRC = 11,
    parameter int DW   = 32,
    parameter int AW   = 12,
    localparam int BW  = DW / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_rd,
    input  logic            reg_wr,
    input  logic [BW-1:0]   reg_be,
    input  logic [DW-1:0]   reg_wdata,
    input  logic [NSRC-1:0] level,
    input  logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] ena,
    output logic [NSRC-1:0] cls,
    output logic [DW-1:0]   tgt0,
    output logic [DW-1:0]   tgt1,
    output logic [DW-1:0]   rdata,
    output logic            pend_clr
);
    assign pend_clr = (reg_rd || reg_wr) && (reg_addr == AW'(OFS_PEND));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena  <= '0;
            cls  <= '0;
            tgt0 <= '0;
            tgt1 <= '0;
        end else if (reg_wr) begin
            if (reg_addr == AW'(OFS_TGT0)) begin
                for (int i = 0; i < DW; i++)
                    if (reg_be[i/8]) tgt0[i] <= reg_wdata[i];
            end
            if (reg_addr == AW'(OFS_TGT1)) begin
                for (int i = 0; i < DW; i++)
                    if (reg_be[i/8]) tgt1[i] <= reg_wdata[i];
            end
            if (reg_addr == AW'(OFS_ENA)) begin
                for (int i = 0; i < NSRC; i++)
                    if (reg_be[i/8]) ena[i] <= reg_wdata[i];
            end
            if (reg_addr == AW'(OFS_CLASS)) begin
                for (int i = 0; i < NSRC; i++)
                    if (reg_be[i/8]) cls[i] <= reg_wdata[i];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_addr)
            AW'(OFS_TGT0):   rdata = tgt0;
            AW'(OFS_TGT1):   rdata = tgt1;
            AW'(OFS_ROUTE0): rdata[NSRC-1:0] = level & ena & ~cls;
            AW'(OFS_ROUTE1): rdata[NSRC-1:0] = level & ena & cls;
            AW'(OFS_ENA):    rdata[NSRC-1:0] = ena;
            AW'(OFS_PEND):   rdata[NSRC-1:0] = pend;
            AW'(OFS_CLASS):  rdata[NSRC-1:0] = cls;
            AW'(OFS_LEVEL):  rdata[NSRC-1:0] = level;
            default:         rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_msg_dispatch.sv
module irq_msg_dispatch
    import irq_msg_pkg::*;
#(
    parameter int NSRC  = 11,
    parameter int DW    = 32,
    parameter int ALIGN = 5,
    localparam int IDXW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] rise,
    input  logic [NSRC-1:0] ena,
    input  logic [NSRC-1:0] cls,
    input  logic [DW-1:0]   tgt0,
    input  logic [DW-1:0]   tgt1,
    input  logic            msg_ready,
    output logic            msg_valid,
    output logic [DW-1:0]   msg_addr,
    output logic [DW-1:0]   msg_data
);
    disp_state_e     state_q, state_d;
    logic [NSRC-1:0] queue_q, class_q, new_q, take_vec;
    logic [IDXW-1:0] pick_idx;
    logic            pick_hit, load;
    logic [DW-1:0]   sel_tgt;

    // lowest queued index wins
    always_comb begin
        pick_hit = 1'b0;
        pick_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (queue_q[i]) begin
                pick_hit = 1'b1;
                pick_idx = IDXW'(i);
            end
        end
    end

    assign load     = (state_q == ST_IDLE) && pick_hit;
    assign take_vec = load ? (NSRC'(1) << pick_idx) : '0;
    assign new_q    = rise & ena;
    assign sel_tgt  = class_q[pick_idx] ? tgt1 : tgt0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (pick_hit)  state_d = ST_SEND;
            ST_SEND: if (msg_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            queue_q <= '0;
            class_q <= '0;
        end else begin
            queue_q <= (queue_q & ~take_vec) | new_q;
            class_q <= (class_q & ~new_q) | (cls & new_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_addr <= '0;
            msg_data <= '0;
        end else if (load) begin
            msg_addr <= {sel_tgt[DW-1:ALIGN], {ALIGN{1'b0}}};
            msg_data <= {{(DW-ALIGN){1'b0}}, sel_tgt[ALIGN-1:0]};
        end
    end

    assign msg_valid = (state_q == ST_SEND);
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl #(
    parameter int                NSRC      = 11,
    parameter int                DW        = 32,
    parameter int                AW        = 12,
    parameter int                ALIGN     = 5,
    parameter logic [NSRC-1:0]   IMPL_MASK = 11'h5FF,
    localparam int               BW        = DW / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_rd,
    input  logic            reg_wr,
    input  logic [BW-1:0]   reg_be,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [NSRC-1:0] src_lvl,
    output logic            msg_valid,
    input  logic            msg_ready,
    output logic [DW-1:0]   msg_addr,
    output logic [DW-1:0]   msg_data
);
    logic [NSRC-1:0] level, pend, rise, ena, cls;
    logic [DW-1:0]   tgt0, tgt1;
    logic            pend_clr;

    irq_msg_capture #(.NSRC(NSRC), .IMPL_MASK(IMPL_MASK)) u_capture (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .pend_clr(pend_clr),
        .level(level), .pend(pend), .rise(rise)
    );

    irq_msg_regs #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .level(level), .pend(pend), .ena(ena), .cls(cls),
        .tgt0(tgt0), .tgt1(tgt1), .rdata(reg_rdata), .pend_clr(pend_clr)
    );

    irq_msg_dispatch #(.NSRC(NSRC), .DW(DW), .ALIGN(ALIGN)) u_dispatch (
        .clk(clk), .rst_n(rst_n), .rise(rise), .ena(ena), .cls(cls),
        .tgt0(tgt0), .tgt1(tgt1), .msg_ready(msg_ready),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
    );
endmodule

// File: rtl/irq_msg_ctrl_chk.sv
module irq_msg_ctrl_chk
    import irq_msg_pkg::*;
#(
    parameter int              NSRC      = 11,
    parameter int              DW        = 32,
    parameter int              AW        = 12,
    parameter int              ALIGN     = 5,
    parameter logic [NSRC-1:0] IMPL_MASK = 11'h5FF
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   reg_addr,
    input logic            reg_rd,
    input logic [DW-1:0]   reg_rdata,
    input logic [NSRC-1:0] src_lvl,
    input logic            msg_valid,
    input logic            msg_ready,
    input logic [DW-1:0]   msg_addr,
    input logic [DW-1:0]   msg_data
);
    logic narrow_reg, known_reg;

    assign narrow_reg = (reg_addr == AW'(OFS_ROUTE0)) || (reg_addr == AW'(OFS_ROUTE1)) ||
                        (reg_addr == AW'(OFS_ENA))    || (reg_addr == AW'(OFS_PEND))   ||
                        (reg_addr == AW'(OFS_CLASS))  || (reg_addr == AW'(OFS_LEVEL));
    assign known_reg  = narrow_reg || (reg_addr == AW'(OFS_TGT0)) || (reg_addr == AW'(OFS_TGT1));

    a_r11_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

    a_r11_gap_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready |=> !msg_valid);

    a_r8_message_format: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[ALIGN-1:0] == '0) && (msg_data[DW-1:ALIGN] == '0));

    a_r2_level_tracks_src: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && reg_rd && (reg_addr == AW'(OFS_LEVEL)) |->
            reg_rdata == {{(DW-NSRC){1'b0}}, $past(src_lvl) & IMPL_MASK});

    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && !known_reg |-> reg_rdata == '0);

    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && narrow_reg |-> reg_rdata[DW-1:NSRC] == '0);
endmodule

bind irq_msg_ctrl irq_msg_ctrl_chk #(
    .NSRC(NSRC), .DW(DW), .AW(AW), .ALIGN(ALIGN), .IMPL_MASK(IMPL_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .src_lvl(src_lvl), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/irq_msg_ctrl_bench.sv
module irq_msg_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [10:0] MASK = 11'h5FF;

    logic        clk = 0, rst_n = 0;
    logic [11:0] reg_addr = '0;
    logic        reg_rd = 0, reg_wr = 0, msg_ready = 0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, msg_addr, msg_data;
    logic [10:0] src_lvl = '0;
    logic        msg_valid;

    int total = 0, fails = 0, acc_cnt = 0;
    logic [31:0] acc_log [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_msg_ctrl u_irq_msg_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .src_lvl(src_lvl), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [10:0] m_ilr, m_ipr, m_imr, m_icr, m_q, m_cls;
    logic [31:0] m_t0, m_t1, m_addr, m_data;
    bit          m_valid;

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] w, input logic [3:0] be);
        for (int b = 0; b < 4; b++) if (be[b]) o[8*b +: 8] = w[8*b +: 8];
        return o;
    endfunction

    function automatic logic [31:0] mread(input logic [11:0] a);
        case (a)
            12'h004: return m_t0;
            12'h010: return m_t1;
            12'h00C: return {21'b0, m_ilr & m_imr & ~m_icr};
            12'h014: return {21'b0, m_ilr & m_imr & m_icr};
            12'h018: return {21'b0, m_imr};
            12'h01C: return {21'b0, m_ipr};
            12'h024: return {21'b0, m_icr};
            12'h028: return {21'b0, m_ilr};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rtag(input logic [11:0] a);
        case (a)
            12'h028: return "R2";
            12'h01C: return "R4";
            12'h00C, 12'h014: return "R5";
            default: return "R7";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ilr = '0; m_ipr = '0; m_imr = '0; m_icr = '0; m_q = '0; m_cls = '0;
            m_t0 = '0; m_t1 = '0; m_addr = '0; m_data = '0; m_valid = 0;
        end else begin
            logic [10:0] rise;
            logic [31:0] sel, tmp;
            int pick;
            rise = src_lvl & MASK & ~m_ilr;
            if (m_valid) begin
                if (msg_ready) m_valid = 0;
            end else begin
                pick = -1;
                for (int i = 10; i >= 0; i--) if (m_q[i]) pick = i;
                if (pick >= 0) begin
                    sel = m_cls[pick] ? m_t1 : m_t0;
                    m_addr = {sel[31:5], 5'b0};
                    m_data = {27'b0, sel[4:0]};
                    m_q[pick] = 1'b0;
                    m_valid = 1;
                end
            end
            for (int i = 0; i < 11; i++)
                if (rise[i] && m_imr[i]) begin m_q[i] = 1'b1; m_cls[i] = m_icr[i]; end
            if ((reg_rd || reg_wr) && reg_addr == 12'h01C) m_ipr = '0;
            m_ipr = m_ipr | rise;
            if (reg_wr) begin
                case (reg_addr)
                    12'h004: m_t0 = mrg(m_t0, reg_wdata, reg_be);
                    12'h010: m_t1 = mrg(m_t1, reg_wdata, reg_be);
                    12'h018: begin tmp = mrg({21'b0, m_imr}, reg_wdata, reg_be); m_imr = tmp[10:0]; end
                    12'h024: begin tmp = mrg({21'b0, m_icr}, reg_wdata, reg_be); m_icr = tmp[10:0]; end
                    default: ;
                endcase
            end
            m_ilr = src_lvl & MASK;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(msg_valid == m_valid, "R11 valid", {31'b0, msg_valid}, {31'b0, m_valid});
            if (m_valid) begin
                chk(msg_addr == m_addr, "R8 addr", msg_addr, m_addr);
                chk(msg_data == m_data, "R8 data", msg_data, m_data);
            end
            if (reg_rd) chk(reg_rdata == mread(reg_addr), rtag(reg_addr), reg_rdata, mread(reg_addr));
        end
    end

    always @(posedge clk)
        if (rst_n && msg_valid && msg_ready) begin
            acc_log[acc_cnt % 64] <= msg_addr;
            acc_cnt <= acc_cnt + 1;
        end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
        reg_addr = a; reg_be = be; reg_wdata = d; reg_wr = 1;
        cyc();
        reg_wr = 0; reg_be = '0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a; reg_rd = 1;
        @(negedge clk);
        chk(reg_rdata == exp, tag, reg_rdata, exp);
        @(posedge clk); #1;
        reg_rd = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R11 watchdog expired", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int base;
        cyc(3);
        rst_n = 1;
        cyc();
        // R1: reset state
        chk(msg_valid == 0, "R1 msg_valid", {31'b0, msg_valid}, 32'h0);
        foreach (u_offsets[i]) rd_chk(u_offsets[i], 32'h0, "R1 reset value");

        // R7: byte-lane writes
        wr_reg(12'h004, 4'b0011, 32'hFFFF_5687);
        wr_reg(12'h004, 4'b1100, 32'h1234_FFFF);
        wr_reg(12'h010, 4'b1111, 32'hABCD_EF3F);
        wr_reg(12'h018, 4'b1111, 32'hFFFF_FFFF);
        wr_reg(12'h024, 4'b0001, 32'h0000_0004);
        rd_chk(12'h004, 32'h1234_5687, "R7 lane merge target-0");
        rd_chk(12'h018, 32'h0000_07FF, "R7 enable width");

        // R12 latency and R8 content
        msg_ready = 1;
        src_lvl = 11'h001;
        cyc();
        chk(msg_valid == 0, "R12 not yet valid", {31'b0, msg_valid}, 32'h0);
        cyc();
        chk(msg_valid == 1, "R12 valid next edge", {31'b0, msg_valid}, 32'h1);
        chk(msg_addr == 32'h1234_5680, "R8 address", msg_addr, 32'h1234_5680);
        chk(msg_data == 32'h0000_0007, "R8 data", msg_data, 32'h7);
        cyc();
        chk(msg_valid == 0, "R11 gap after accept", {31'b0, msg_valid}, 32'h0);
        rd_chk(12'h028, 32'h001, "R2 level");
        rd_chk(12'h01C, 32'h001, "R3 pending set");
        rd_chk(12'h01C, 32'h000, "R4 read clears");

        // R10 ordering with class split
        msg_ready = 0;
        base = acc_cnt;
        src_lvl = 11'h027;
        cyc(4);
        chk(msg_valid == 1, "R11 held", {31'b0, msg_valid}, 32'h1);
        rd_chk(12'h00C, 32'h023, "R5 routed class 0");
        rd_chk(12'h014, 32'h004, "R5 routed class 1");
        msg_ready = 1;
        cyc(8);
        chk(acc_cnt - base == 3, "R10 message count", acc_cnt - base, 3);
        chk(acc_log[base % 64] == 32'h1234_5680, "R10 order first", acc_log[base % 64], 32'h1234_5680);
        chk(acc_log[(base+1) % 64] == 32'hABCD_EF20, "R10 order second", acc_log[(base+1) % 64], 32'hABCD_EF20);
        chk(acc_log[(base+2) % 64] == 32'h1234_5680, "R10 order third", acc_log[(base+2) % 64], 32'h1234_5680);

        // R3 fall keeps pending, R4 write clears
        src_lvl = 11'h000;
        cyc();
        rd_chk(12'h01C, 32'h026, "R3 fall keeps pending");
        src_lvl = 11'h001;
        cyc();
        src_lvl = 11'h000;
        cyc();
        wr_reg(12'h01C, 4'b0001, 32'h0);
        rd_chk(12'h01C, 32'h000, "R4 write clears");
        // rise at same edge as clear survives
        src_lvl = 11'h008;
        wr_reg(12'h01C, 4'b1111, 32'hFFFF_FFFF);
        rd_chk(12'h01C, 32'h008, "R4 rise beats clear");

        // R2 bit 9 unimplemented
        src_lvl = 11'h208;
        cyc();
        rd_chk(12'h028, 32'h008, "R2 bit 9 reads zero");
        cyc(4);

        // R9 disabled rise never sends
        wr_reg(12'h018, 4'b1111, 32'h0000_07F7);
        src_lvl = 11'h000;
        cyc();
        base = acc_cnt;
        src_lvl = 11'h008;
        cyc();
        wr_reg(12'h018, 4'b1111, 32'h0000_07FF);
        cyc(6);
        chk(acc_cnt == base, "R9 no message", acc_cnt - base, 0);

        // R10 merge of a re-rise while queued
        msg_ready = 0;
        base = acc_cnt;
        src_lvl = 11'h010; cyc();
        src_lvl = 11'h050; cyc();
        src_lvl = 11'h010; cyc();
        src_lvl = 11'h050; cyc();
        msg_ready = 1;
        cyc(8);
        chk(acc_cnt - base == 2, "R10 merged count", acc_cnt - base, 2);

        // R6 read-only, R7 unmapped
        wr_reg(12'h028, 4'b1111, 32'hFFFF_FFFF);
        wr_reg(12'h00C, 4'b1111, 32'hFFFF_FFFF);
        wr_reg(12'h014, 4'b1111, 32'hFFFF_FFFF);
        rd_chk(12'h028, 32'h050, "R6 level write ignored");
        rd_chk(12'h014, 32'h000, "R6 routed write ignored");
        wr_reg(12'h030, 4'b1111, 32'hFFFF_FFFF);
        rd_chk(12'h030, 32'h0, "R7 unmapped reads zero");
        rd_chk(12'h024, 32'h004, "R7 unmapped write no effect");

        // mixed traffic against the model
        for (int n = 0; n < 800; n++) begin
            src_lvl   = src_lvl ^ (11'($urandom) & 11'($urandom) & 11'($urandom));
            msg_ready = ($urandom % 3) != 0;
            reg_rd    = ($urandom % 4) == 0;
            reg_wr    = !reg_rd && (($urandom % 6) == 0);
            reg_addr  = u_offsets[$urandom % 10];
            reg_be    = 4'($urandom);
            reg_wdata = $urandom;
            cyc();
        end
        reg_rd = 0; reg_wr = 0; msg_ready = 1;
        cyc(30);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    logic [11:0] u_offsets [0:9] = '{12'h004, 12'h00C, 12'h010, 12'h014, 12'h018,
                                     12'h01C, 12'h024, 12'h028, 12'h030, 12'h000};
endmodule